// File: doc/BRIEF.md
# Reconfigurable Array Processing Element

This block is the compute cell of a coarse-grained reconfigurable array. It combines two 16-bit word operands in an ALU and three 1-bit operands through an 8-entry lookup table. Every operand first passes an operand stage. In pass-through mode the stage forwards the live input. In registered mode the stage feeds the unit from a register that captured the input one clock earlier.

A configuration port with separate write and read strobes sets the ALU operation, the five operand-stage modes and the lookup-table contents. The same port can load the operand registers directly and can read back every configurable word. A global stall input freezes the operand registers. Configuration loads still take effect while stalled, so a stalled cell can be given constant operands.

The multiplier is the one costly unit in this cell. It receives zeros on both operand inputs unless the multiply operation is selected. Both of its gated inputs are brought out as observation ports.

Top module: `rpe_core`

## Requirements
- R1: After a synchronous active-high reset, all operand registers hold zero, every operand stage is in pass-through mode, the lookup table is zero and the operation is add, so that res_word equals in_a + in_b.
- R2: In pass-through mode, res_word responds combinationally to in_a and in_b in the same cycle.
- R3: ALU operation code at cfg address 0, bits [1:0]: 0 = add, 1 = in_a minus in_b, 2 = low 16 bits of the product, 3 = pass in_a. All arithmetic wraps modulo 2^16.
- R4: The modes are set at cfg address 1, one bit per operand, where 1 means registered: bit 0 for A, bit 1 for B, bits 2, 3 and 4 for flag operands 0, 1 and 2. With stall low, a registered operand is the input value from the previous clock edge.
- R5: While stall is high, operand registers keep their value. After reset with stall high, registered add mode gives res_word = 0 whatever the inputs do.
- R6: A cfg write to address 3 loads the A register from bits [31:16] and the B register from bits [15:0]. This load takes precedence over stall and capture. With both set to 0x0042 and registered add under stall, res_word is 0x0084.
- R7: A cfg write to address 4 loads the flag registers 0, 1 and 2 from bits 0, 1 and 2. This load also takes precedence over stall.
- R8: res_flag equals bit {f2,f1,f0} of the 8-bit table at cfg address 2, bits [7:0], where f0, f1 and f2 are the effective flag operands after the mode is applied.
- R9: While cfg_re is high, cfg_rdata shows the addressed word: opcode, modes, table, {A reg, B reg}, or {flag2, flag1, flag0} in the low bits, with the remaining bits zero. An unmapped address reads zero, and cfg_rdata is zero while cfg_re is low.
- R10: mul_in_a and mul_in_b carry the effective word operands only while operation 2 is selected, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freezes operand registers |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_re | input | 1 | Configuration read strobe |
| cfg_rdata | output | 32 | Configuration readback data |
| in_a | input | 16 | Word operand A |
| in_b | input | 16 | Word operand B |
| in_f0 | input | 1 | Flag operand 0 |
| in_f1 | input | 1 | Flag operand 1 |
| in_f2 | input | 1 | Flag operand 2 |
| res_word | output | 16 | ALU result |
| res_flag | output | 1 | Lookup-table result |
| mul_in_a | output | 16 | Gated multiplier input A |
| mul_in_b | output | 16 | Gated multiplier input B |

## Verification
Random word operands drive each of the four operations in pass-through mode. This separates the opcodes from one another and detects an operand order swapped in subtract. A registered-mode stream with stall low checks that the result follows the previous cycle's inputs and not the live ones. Stalled streams, starting from reset and then after a direct register load, confirm that changing inputs leave the result untouched. Random table values paired with random flag inputs check the table index order, and readback plus the multiplier observation ports show the stored fields and the input gating.

// File: rtl/rpe_pkg.sv
package rpe_pkg;
    localparam int DW      = 16;
    localparam int CW      = 32;
    localparam int AW      = 8;
    localparam int NFLAG   = 3;
    localparam int NMODE   = 2 + NFLAG;
    localparam int LUT_W   = 1 << NFLAG;

    localparam logic [AW-1:0] A_OPC  = 8'd0;
    localparam logic [AW-1:0] A_MODE = 8'd1;
    localparam logic [AW-1:0] A_LUT  = 8'd2;
    localparam logic [AW-1:0] A_WREG = 8'd3;
    localparam logic [AW-1:0] A_FREG = 8'd4;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_MUL  = 2'd2,
        OP_PASS = 2'd3
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [NMODE-1:0] mode;
        logic [LUT_W-1:0] lut;
    } cfg_t;

    function automatic logic lut_pick(input logic [LUT_W-1:0] tbl,
                                      input logic [NFLAG-1:0] idx);
        return tbl[idx];
    endfunction
endpackage

// File: rtl/rpe_opreg.sv
module rpe_opreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stall,
    input  logic         delay_en,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (load_en) q <= load_val;
        else if (!stall)  q <= din;
    end

    assign dout = delay_en ? q : din;
endmodule

// File: rtl/rpe_cfg.sv
module rpe_cfg
    import rpe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [CW-1:0]    cfg_wdata,
    input  logic             cfg_we,
    input  logic             cfg_re,
    input  logic [DW-1:0]    a_q,
    input  logic [DW-1:0]    b_q,
    input  logic [NFLAG-1:0] f_q,
    output cfg_t             cfg,
    output logic             wreg_load,
    output logic             freg_load,
    output logic [CW-1:0]    cfg_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.op   <= OP_ADD;
            cfg.mode <= '0;
            cfg.lut  <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                A_OPC:   cfg.op   <= op_e'(cfg_wdata[1:0]);
                A_MODE:  cfg.mode <= cfg_wdata[NMODE-1:0];
                A_LUT:   cfg.lut  <= cfg_wdata[LUT_W-1:0];
                default: ;
            endcase
        end
    end

    assign wreg_load = cfg_we && (cfg_addr == A_WREG);
    assign freg_load = cfg_we && (cfg_addr == A_FREG);

    always_comb begin
        cfg_rdata = '0;
        if (cfg_re) begin
            case (cfg_addr)
                A_OPC:   cfg_rdata[1:0]       = cfg.op;
                A_MODE:  cfg_rdata[NMODE-1:0] = cfg.mode;
                A_LUT:   cfg_rdata[LUT_W-1:0] = cfg.lut;
                A_WREG:  cfg_rdata            = {a_q, b_q};
                A_FREG:  cfg_rdata[NFLAG-1:0] = f_q;
                default: cfg_rdata            = '0;
            endcase
        end
    end
endmodule

// File: rtl/rpe_alu.sv
module rpe_alu
    import rpe_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res,
    output logic [DW-1:0] mul_a,
    output logic [DW-1:0] mul_b
);
    logic [2*DW-1:0] prod;

    // operand isolation: the multiplier only toggles when selected
    assign mul_a = (op == OP_MUL) ? a : '0;
    assign mul_b = (op == OP_MUL) ? b : '0;
    assign prod  = mul_a * mul_b;

    always_comb begin
        case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_MUL:  res = prod[DW-1:0];
            default: res = a;
        endcase
    end
endmodule

// File: rtl/rpe_core.sv
module rpe_core
    import rpe_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          stall,
    input  logic [7:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    input  logic          cfg_we,
    input  logic          cfg_re,
    output logic [31:0]   cfg_rdata,
    input  logic [15:0]   in_a,
    input  logic [15:0]   in_b,
    input  logic          in_f0,
    input  logic          in_f1,
    input  logic          in_f2,
    output logic [15:0]   res_word,
    output logic          res_flag,
    output logic [15:0]   mul_in_a,
    output logic [15:0]   mul_in_b
);
    cfg_t             cfg;
    op_e              op_sel;
    logic             wreg_load, freg_load;
    logic [DW-1:0]    a_q, b_q, a_eff, b_eff;
    logic [NFLAG-1:0] f_in, f_q, f_eff;

    assign f_in   = {in_f2, in_f1, in_f0};
    assign op_sel = cfg.op;

    rpe_cfg u_cfg (
        .clk(clk), .rst(rst),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_we(cfg_we), .cfg_re(cfg_re),
        .a_q(a_q), .b_q(b_q), .f_q(f_q),
        .cfg(cfg), .wreg_load(wreg_load), .freg_load(freg_load),
        .cfg_rdata(cfg_rdata)
    );

    rpe_opreg #(.W(DW)) u_reg_a (
        .clk(clk), .rst(rst), .stall(stall), .delay_en(cfg.mode[0]),
        .load_en(wreg_load), .load_val(cfg_wdata[CW-1:DW]),
        .din(in_a), .q(a_q), .dout(a_eff)
    );

    rpe_opreg #(.W(DW)) u_reg_b (
        .clk(clk), .rst(rst), .stall(stall), .delay_en(cfg.mode[1]),
        .load_en(wreg_load), .load_val(cfg_wdata[DW-1:0]),
        .din(in_b), .q(b_q), .dout(b_eff)
    );

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        rpe_opreg #(.W(1)) u_reg_f (
            .clk(clk), .rst(rst), .stall(stall), .delay_en(cfg.mode[2+g]),
            .load_en(freg_load), .load_val(cfg_wdata[g]),
            .din(f_in[g]), .q(f_q[g]), .dout(f_eff[g])
        );
    end

    rpe_alu u_alu (
        .op(cfg.op), .a(a_eff), .b(b_eff),
        .res(res_word), .mul_a(mul_in_a), .mul_b(mul_in_b)
    );

    assign res_flag = lut_pick(cfg.lut, f_eff);
endmodule

// File: rtl/rpe_checks.sv
module rpe_checks
    import rpe_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          stall,
    input logic [7:0]    cfg_addr,
    input logic [31:0]   cfg_wdata,
    input logic          cfg_we,
    input logic          cfg_re,
    input logic [31:0]   cfg_rdata,
    input logic [15:0]   in_a,
    input logic [15:0]   a_q,
    input logic [15:0]   res_word,
    input logic [15:0]   mul_in_a,
    input logic [15:0]   mul_in_b,
    input op_e           op_sel
);
    // R10: multiplier inputs idle unless multiply is selected
    a_r10_mul_gated: assert property (@(posedge clk) disable iff (rst)
        (op_sel != OP_MUL) |-> (mul_in_a == 16'd0 && mul_in_b == 16'd0));

    // R3: multiply result comes from the gated multiplier inputs
    a_r3_mul_result: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_MUL) |-> (res_word == 16'(mul_in_a * mul_in_b)));

    // R5: stall freezes the operand register
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (stall && !(cfg_we && cfg_addr == A_WREG)) |=> $stable(a_q));

    // R4: without stall the register captures the previous input
    a_r4_capture: assert property (@(posedge clk) disable iff (rst)
        (!stall && !(cfg_we && cfg_addr == A_WREG)) |=> (a_q == $past(in_a)));

    // R6: direct load of the word register
    a_r6_direct_load: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == A_WREG) |=> (a_q == $past(cfg_wdata[31:16])));

    // R9: idle read port drives zero
    a_r9_read_idle: assert property (@(posedge clk) disable iff (rst)
        !cfg_re |-> (cfg_rdata == 32'd0));
endmodule

bind rpe_core rpe_checks u_rpe_checks (
    .clk(clk), .rst(rst), .stall(stall),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_we(cfg_we),
    .cfg_re(cfg_re), .cfg_rdata(cfg_rdata),
    .in_a(in_a), .a_q(a_q), .res_word(res_word),
    .mul_in_a(mul_in_a), .mul_in_b(mul_in_b), .op_sel(op_sel)
);

// File: tb/test_rpe_core.sv
module test_rpe_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_re = 1'b0;
    logic [31:0] cfg_rdata;
    logic [15:0] in_a = '0, in_b = '0;
    logic        in_f0 = 1'b0, in_f1 = 1'b0, in_f2 = 1'b0;
    logic [15:0] res_word, mul_in_a, mul_in_b;
    logic        res_flag;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    rpe_core i_rpe_core (
        .clk(clk), .rst(rst), .stall(stall),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_we(cfg_we),
        .cfg_re(cfg_re), .cfg_rdata(cfg_rdata),
        .in_a(in_a), .in_b(in_b), .in_f0(in_f0), .in_f1(in_f1), .in_f2(in_f2),
        .res_word(res_word), .res_flag(res_flag),
        .mul_in_a(mul_in_a), .mul_in_b(mul_in_b)
    );

    function automatic logic [15:0] alu_ref(input int op, input logic [15:0] a,
                                            input logic [15:0] b);
        logic [31:0] p;
        p = a * b;
        case (op)
            0: return a + b;
            1: return a - b;
            2: return p[15:0];
            default: return a;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        cfg_addr = addr; cfg_wdata = data; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_check(input string req, input logic [7:0] addr,
                             input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = addr; cfg_re = 1'b1;
        #5 check(req, cfg_rdata, exp);
        cfg_re = 1'b0;
        #1 check(req, cfg_rdata, 32'd0);
    endtask

    initial begin
        logic [15:0] pa, pb;
        void'($urandom(32'd1234));
        do_reset();

        // R1: reset state
        cfg_check("R1", 8'd0, 32'd0);
        cfg_check("R1", 8'd1, 32'd0);
        cfg_check("R1", 8'd3, 32'd0);
        @(negedge clk);
        in_a = 16'h1234; in_b = 16'h0101;
        #5 check("R1", res_word, 16'h1335);

        // R2 R3 R10: pass-through, every opcode, random plus corners
        for (int op = 0; op < 4; op++) begin
            cfg_write(8'd0, op);
            cfg_check("R9", 8'd0, op);
            for (int k = 0; k < 24; k++) begin
                @(negedge clk);
                if (k == 0)      begin in_a = 16'hFFFF; in_b = 16'h0001; end
                else if (k == 1) begin in_a = 16'h0000; in_b = 16'h0001; end
                else begin in_a = 16'($urandom); in_b = 16'($urandom); end
                #5;
                check("R3", res_word, alu_ref(op, in_a, in_b));
                check("R10", mul_in_a, (op == 2) ? in_a : 16'd0);
                check("R10", mul_in_b, (op == 2) ? in_b : 16'd0);
            end
        end

        // R4: registered mode follows the previous inputs
        cfg_write(8'd0, 32'd1);
        cfg_write(8'd1, 32'h03);
        cfg_check("R9", 8'd1, 32'h03);
        @(negedge clk);
        in_a = 16'($urandom); in_b = 16'($urandom);
        for (int k = 0; k < 20; k++) begin
            pa = in_a; pb = in_b;
            @(negedge clk);
            in_a = 16'($urandom); in_b = 16'($urandom);
            #5 check("R4", res_word, 16'(pa - pb));
        end

        // R5: stall from reset keeps add result at zero
        do_reset();
        stall = 1'b1;
        cfg_write(8'd1, 32'h03);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            in_a = 16'(k + 1); in_b = 16'(k + 1);
            #5 check("R5", res_word, 16'd0);
        end

        // R6: direct load under stall
        cfg_write(8'd3, 32'h0042_0042);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            in_a = 16'($urandom); in_b = 16'($urandom);
            #5 check("R6", res_word, 16'h0084);
        end
        cfg_check("R9", 8'd3, 32'h0042_0042);
        cfg_write(8'd3, 32'h1111_0022);
        cfg_check("R6", 8'd3, 32'h1111_0022);

        // R7 R8: flag registers loaded under stall with an AND table
        do_reset();
        stall = 1'b1;
        cfg_write(8'd2, 32'h80);
        cfg_write(8'd1, 32'h1C);
        cfg_write(8'd4, 32'h7);
        @(negedge clk);
        in_f0 = 0; in_f1 = 0; in_f2 = 0;
        #5 check("R7", res_flag, 1'b1);
        cfg_check("R7", 8'd4, 32'h7);
        cfg_check("R9", 8'd2, 32'h80);
        cfg_check("R9", 8'd9, 32'h0);

        // R8: pass-through flags, random tables
        stall = 1'b0;
        cfg_write(8'd1, 32'h00);
        for (int k = 0; k < 24; k++) begin
            logic [7:0] t;
            logic [2:0] ix;
            t = 8'($urandom);
            cfg_write(8'd2, {24'd0, t});
            @(negedge clk);
            ix = 3'($urandom);
            {in_f2, in_f1, in_f0} = ix;
            #5 check("R8", res_flag, t[ix]);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule